// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block adds or subtracts two 64-bit packed operands as a set of independent lanes. A lane-width select splits the carry chain into eight 8-bit, four 16-bit or two 32-bit lanes. Carries never cross a lane boundary. Each lane is read as either signed or unsigned, and has its own overflow detector.

When saturation is enabled, a lane that overflows is clamped to the extreme value it can hold, in the direction of the overflow. Otherwise the lane keeps its modulo result. In both cases the per-lane overflow flags are reported.

The block suits packed media arithmetic such as audio clipping and pixel saturation. One operation is accepted per cycle. The registered result appears on the clock edge that samples a valid input.

Top module: `simd_sat_adder`

## Requirements
- R1: Result, flags and `out_valid` update on the rising edge that samples `in_valid` high, so the result is available one cycle after a valid input. After a cycle with `in_valid` low, `out_valid` is 0 and `result` and `ovf` keep their values. After reset, `out_valid`, `result` and `ovf` are all 0.
- R2: `lane_mode` sets the lane width. The value 0 selects eight 8-bit lanes, 1 selects four 16-bit lanes, and 2 or 3 select two 32-bit lanes. Lane k occupies bits [k*W+W-1 : k*W].
- R3: No carry or borrow propagates from one lane into the next in the selected mode.
- R4: With `sub_en`=1, each lane computes a + (~b) + 1 modulo 2^W, where W is the lane width. With `sub_en`=0, each lane computes a + b modulo 2^W.
- R5: For signed addition (`signed_en`=1), a lane overflows only when both operands share a sign and the result sign differs from it.
- R6: For signed subtraction, a lane overflows only when the operands differ in sign. This is the case when a non-negative minus a negative gives sign 1, or a negative minus a non-negative gives sign 0.
- R7: For unsigned lanes (`signed_en`=0), addition overflows on a carry out of the lane MSB. Subtraction overflows on a borrow, which happens when a < b.
- R8: With `sat_en`=1 and signed lanes, an overflowing lane gives 2^(W-1)-1 on positive overflow and -2^(W-1) on negative overflow.
- R9: With `sat_en`=1 and unsigned lanes, an overflowing addition gives all ones and an overflowing subtraction gives zero.
- R10: With `sat_en`=0, every lane holds its modulo result even when it overflows, and the overflow flags are still reported.
- R11: `ovf` bit j belongs to byte j (bits [8j+7:8j]). Each lane's flag is copied to every byte position the lane covers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_a | input | 64 | Packed first operand |
| op_b | input | 64 | Packed second operand |
| lane_mode | input | 2 | Lane width: 0=8, 1=16, 2/3=32 bits |
| sub_en | input | 1 | 1 = a minus b, 0 = a plus b |
| sat_en | input | 1 | 1 = saturating, 0 = wrapping |
| signed_en | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Packed lane results |
| ovf | output | 8 | Per-byte-position overflow flags |

## Verification
The random stimulus mixes all four lane modes with every combination of add/subtract, signed/unsigned and wrap/saturate. This separates faults in lane partitioning from faults in overflow detection and in clamping.

Directed operands target specific failures:
- Bytes of 0xFF plus 1 reveal any carry that leaks across a lane boundary.
- Sign-edge values such as 0x7F+1 and 0x80-1 tell positive from negative saturation.
- An unsigned 0-1 tells a borrow apart from a carry.

An idle cycle confirms that the outputs hold, and mode 3 is checked to behave as 32-bit lanes.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
    parameter int unsigned DATA_W = 64;
    parameter int unsigned BYTE_W = 8;
    localparam int unsigned NBYTES = DATA_W / BYTE_W;
    localparam int unsigned IDX_W  = $clog2(NBYTES);

    typedef enum logic [1:0] {
        LANE_W8    = 2'd0,
        LANE_W16   = 2'd1,
        LANE_W32   = 2'd2,
        LANE_W32_X = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] sum;
        logic [NBYTES-1:0] ovf;
    } out_state_t;
endpackage

// File: rtl/sat_byte_slice.sv
module sat_byte_slice #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_eff,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         sovf
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
        // sign-rule overflow, valid when this slice holds a lane MSB
        sovf = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/sat_lane_map.sv
module sat_lane_map
    import simd_sat_pkg::*;
(
    input  logic [1:0]                   mode,
    output logic [NBYTES-1:0]            start_mask,
    output logic [NBYTES-1:0][IDX_W-1:0] top_idx
);
    always_comb begin
        for (int i = 0; i < NBYTES; i++) begin
            logic [IDX_W-1:0] idx;
            idx = IDX_W'(i);
            unique case (lane_mode_e'(mode))
                LANE_W8: begin
                    start_mask[i] = 1'b1;
                    top_idx[i]    = idx;
                end
                LANE_W16: begin
                    start_mask[i] = (idx[0] == 1'b0);
                    top_idx[i]    = idx | IDX_W'(1);
                end
                default: begin
                    start_mask[i] = (idx[1:0] == 2'b00);
                    top_idx[i]    = idx | IDX_W'(3);
                end
            endcase
        end
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] wrapped,
    input  logic         lane_ovf,
    input  logic         is_top,
    input  logic         pos_dir,
    input  logic         sat_en,
    input  logic         signed_en,
    input  logic         sub_en,
    output logic [W-1:0] byte_out
);
    logic [W-1:0] clamp_v;

    always_comb begin
        if (signed_en) begin
            if (pos_dir) clamp_v = is_top ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
            else         clamp_v = is_top ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};
        end else begin
            clamp_v = sub_en ? {W{1'b0}} : {W{1'b1}};
        end
        byte_out = (sat_en && lane_ovf) ? clamp_v : wrapped;
    end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        lane_mode,
    input  logic              sub_en,
    input  logic              sat_en,
    input  logic              signed_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [NBYTES-1:0] ovf
);
    logic [NBYTES-1:0]            start_mask;
    logic [NBYTES-1:0][IDX_W-1:0] top_idx;
    logic [DATA_W-1:0]            b_eff;
    logic [DATA_W-1:0]            wrap_sum;
    logic [DATA_W-1:0]            sat_sum;
    logic [NBYTES-1:0]            carry_in;
    logic [NBYTES-1:0]            carry_out;
    logic [NBYTES-1:0]            slice_sovf;
    logic [NBYTES-1:0]            slice_ovf;
    logic [NBYTES-1:0]            lane_flag;
    out_state_t                   state_d, state_q;

    assign b_eff = sub_en ? ~op_b : op_b;

    sat_lane_map u_map (
        .mode       (lane_mode),
        .start_mask (start_mask),
        .top_idx    (top_idx)
    );

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // carry chain cut at lane starts; subtract injects +1 there
        if (i == 0) begin : g_first
            assign carry_in[i] = sub_en;
        end else begin : g_rest
            assign carry_in[i] = start_mask[i] ? sub_en : carry_out[i-1];
        end

        sat_byte_slice #(.W(BYTE_W)) u_slice (
            .a     (op_a[i*BYTE_W +: BYTE_W]),
            .b_eff (b_eff[i*BYTE_W +: BYTE_W]),
            .cin   (carry_in[i]),
            .sum   (wrap_sum[i*BYTE_W +: BYTE_W]),
            .cout  (carry_out[i]),
            .sovf  (slice_sovf[i])
        );

        // unsigned: carry on add, missing carry (borrow) on subtract
        assign slice_ovf[i] = signed_en ? slice_sovf[i] : (carry_out[i] ^ sub_en);
        assign lane_flag[i] = slice_ovf[top_idx[i]];

        sat_clamp #(.W(BYTE_W)) u_clamp (
            .wrapped   (wrap_sum[i*BYTE_W +: BYTE_W]),
            .lane_ovf  (lane_flag[i]),
            .is_top    (top_idx[i] == IDX_W'(i)),
            .pos_dir   (~op_a[top_idx[i]*BYTE_W + BYTE_W - 1]),
            .sat_en    (sat_en),
            .signed_en (signed_en),
            .sub_en    (sub_en),
            .byte_out  (sat_sum[i*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.sum = sat_sum;
            state_d.ovf = lane_flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.sum;
    assign ovf       = state_q.ovf;
endmodule

// File: rtl/sat_adder_chk.sv
module sat_adder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] a_lo,
    input logic [7:0] b_lo,
    input logic [1:0] lane_mode,
    input logic       sub_en,
    input logic       sat_en,
    input logic       signed_en,
    input logic       out_valid,
    input logic [7:0] res_lo,
    input logic [7:0] ovf
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_lo) && $stable(ovf))); // R1
    AST_FLAG_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode == 2'd1) |=>
        (ovf[0] == ovf[1] && ovf[2] == ovf[3] && ovf[4] == ovf[5] && ovf[6] == ovf[7])); // R11
    AST_USAT_ADD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode == 2'd0 && sat_en && !signed_en && !sub_en) |=>
        (!ovf[0] || res_lo == 8'hFF)); // R9
    AST_SSAT_KEEPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode == 2'd0 && sat_en && signed_en && !sub_en && a_lo[7] == b_lo[7]) |=>
        (res_lo[7] == $past(a_lo[7]))); // R8
    AST_WRAP_BYTE0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode == 2'd0 && !sat_en && !sub_en) |=>
        (res_lo == 8'($past(a_lo) + $past(b_lo)))); // R10
endmodule

bind simd_sat_adder sat_adder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_lo      (op_a[7:0]),
    .b_lo      (op_b[7:0]),
    .lane_mode (lane_mode),
    .sub_en    (sub_en),
    .sat_en    (sat_en),
    .signed_en (signed_en),
    .out_valid (out_valid),
    .res_lo    (result[7:0]),
    .ovf       (ovf)
);

// File: tb/tb_simd_sat_adder.sv
module tb_simd_sat_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [1:0]  lane_mode = '0;
    logic        sub_en = 1'b0, sat_en = 1'b0, signed_en = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic [7:0]  ovf;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    simd_sat_adder dut (.*);

    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic [1:0] m, input logic sub, input logic sat,
                                  input logic sgn, output logic [63:0] r, output logic [7:0] f);
        int w = (m == 2'd0) ? 8 : (m == 2'd1) ? 16 : 32;
        longint mask = (longint'(1) << w) - 1;
        r = '0;
        f = '0;
        for (int l = 0; l < 64 / w; l++) begin
            longint ua = longint'(a >> (l * w)) & mask;
            longint ub = longint'(b >> (l * w)) & mask;
            longint s, satv, res;
            bit o;
            if (sgn) begin
                longint mx = (longint'(1) << (w - 1)) - 1;
                longint mn = -(longint'(1) << (w - 1));
                longint sa = (ua > mx) ? ua - (mask + 1) : ua;
                longint sb = (ub > mx) ? ub - (mask + 1) : ub;
                s = sub ? sa - sb : sa + sb;
                o = (s > mx) || (s < mn);
                satv = (s > mx) ? mx : mn;
            end else begin
                s = sub ? ua - ub : ua + ub;
                o = sub ? (ua < ub) : (s > mask);
                satv = sub ? 0 : mask;
            end
            res = (sat && o) ? satv : s;
            r |= 64'(res & mask) << (l * w);
            for (int k = 0; k < w / 8; k++) f[l * w / 8 + k] = o;
        end
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                          input logic sub, input logic sat, input logic sgn, input string tag);
        logic [63:0] er;
        logic [7:0]  ef;
        string rtag, ftag;
        model(a, b, m, sub, sat, sgn, er, ef);
        @(negedge clk);
        op_a = a; op_b = b; lane_mode = m; sub_en = sub; sat_en = sat; signed_en = sgn;
        in_valid = 1'b1;
        @(posedge clk);
        #2;
        rtag = (tag != "") ? tag : sat ? (sgn ? "R8" : "R9") : (sub ? "R4" : "R2");
        ftag = (tag != "") ? tag : sgn ? (sub ? "R6" : "R5") : "R7";
        check({rtag, " result"}, result, er);
        check({ftag, " ovf"}, {56'd0, ovf}, {56'd0, ef});
        check("R1 out_valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [63:0] held_r;
        logic [7:0]  held_f;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        check("R1 reset ovf", {56'd0, ovf}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: carries must stop at each lane boundary
        run_op(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd0, 1'b0, 1'b0, 1'b0, "R3");
        run_op(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd1, 1'b0, 1'b0, 1'b0, "R3");
        run_op(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'd1, 1'b1, 1'b0, 1'b0, "R3");
        // R5 / R8: signed positive and negative saturation in bytes
        run_op(64'h7F80_7F80_7F80_7F80, 64'h0180_0180_0180_0180, 2'd0, 1'b0, 1'b1, 1'b1, "R8");
        // R6: signed subtract across sign
        run_op(64'h8000_7FFF_8000_7FFF, 64'h0001_FFFF_0001_FFFF, 2'd1, 1'b1, 1'b1, 1'b1, "R6");
        // R7 / R9: unsigned borrow clamps to zero
        run_op(64'h0000_0000_0000_0005, 64'h0000_0001_0000_0006, 2'd2, 1'b1, 1'b1, 1'b0, "R9");
        // R10: wrap keeps modulo value but flags overflow
        run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 1'b0, 1'b0, 1'b1, "R10");
        // R11: 16-bit lane flag spans both byte positions
        run_op(64'hFFFF_0000_0000_0000, 64'h0001_0000_0000_0000, 2'd1, 1'b0, 1'b0, 1'b0, "R11");
        // R2: mode 3 behaves as 32-bit lanes
        run_op(64'h0000_00FF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 1'b0, 1'b0, 1'b0, "R2");

        // R1: idle cycle holds outputs
        held_r = result;
        held_f = ovf;
        @(posedge clk);
        #2;
        check("R1 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 idle result hold", result, held_r);
        check("R1 idle ovf hold", {56'd0, ovf}, {56'd0, held_f});

        for (int it = 0; it < 3000; it++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (it % 7 == 0) rb = ~ra;
            run_op(ra, rb, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule